// File: doc/BRIEF.md
# Audio Sample Stream Buffer

This block is the small byte buffer between a memory-side DMA requester and one audio slot (mono) or slot pair (stereo) of a serial audio link. It is built either for playback (bytes come from memory, samples leave on frame ticks) or for record (samples arrive from the link, bytes go to memory). It tracks how many bytes it holds, and it asks the memory side for transfers whose length is chosen so that steady-state bursts land on 16-byte address boundaries. In the playback direction it also produces the per-frame slot-valid tag.

The memory side has three channels. The first is a request channel (`req_valid`/`req_ready`, carrying a byte count). The second is a playback byte channel (`fill_valid`/`fill_ready`). The third is a record byte channel (`drain_valid`/`drain_ready`). A request completes when `req_valid && req_ready` at a rising edge. A byte moves when valid and ready are both high at an edge. `fill_ready` and `drain_valid` are high only while granted bytes are still owed and the channel is running. The memory side may hold off any transfer for as long as it likes by keeping its side of the handshake low. The link side cannot be stalled: a frame tick or an arriving sample is acted on in the cycle it is presented. `addr_lo` (the low address bits of the next memory byte) and `region_left` (bytes left in the current memory region) are kept current by the descriptor logic that sits outside this block.

Top module: `abm_stream_buf`

## Requirements
- R1: The buffer holds up to 24 bytes in the stereo build and 20 bytes in the mono build. A stereo sample is 4 bytes and a mono sample is 2 bytes. `level` reports the byte count held.
- R2: `req_valid` is high exactly when all of the following hold: the channel is enabled, it is not paused, no granted bytes are outstanding, and the movable count is at least the wanted length (which must be nonzero). The movable count is (capacity − level − outstanding) for playback and (level − outstanding) for record.
- R3: Outside start-up, the wanted length is min(16 − `addr_lo`, `region_left`). Such a transfer therefore never crosses a 16-byte boundary.
- R4: Start-up covers playback only, on the first request after an enable. The wanted length is then min(free bytes, `region_left`), so it may exceed 16 bytes.
- R5: After a request handshake, no new request is raised until all `req_len` bytes of that request have moved on the byte channel. During that time the byte channel stays ready (playback) or valid (record).
- R6: Playback: on a frame tick while running with at least one sample buffered, the oldest sample is popped. It appears on `tx_sample` the next cycle with the first-stored byte in bits [7:0], and `tx_tag` is 1. This holds from the first sample after enable.
- R7: Playback underrun: a frame tick while running with less than one sample buffered drives `tx_tag` to 0. It also sets `underrun`, but only if a sample has been sent since the last enable.
- R8: While paused, there are no pops, pushes, requests or byte transfers, and `level` and the contents stay unchanged. `tx_tag` is 0 from the cycle after pause is seen. After resume, output continues with the next stored byte.
- R9: Deasserting `enable` empties the buffer (level 0 the next cycle), drops outstanding bytes and clears `tx_tag`. The next enable begins with a start-up request.
- R10: Record: an arriving sample is stored when the channel is running and at least one sample of space is free. Bytes leave on the drain channel in arrival order, low byte first.
- R11: Record overrun: an arriving sample with less than one sample of space free is dropped, `level` is unchanged, and `overrun` is set.
- R12: `underrun` and `overrun` stay set, across disable too, until a one-cycle pulse on their clear input. A new event in the same cycle as the clear leaves the flag set.
- R13: A byte transfer and a link-side sample in the same cycle both take effect. The level changes by +1 − 4 for stereo playback and by +2 − 1 for mono record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable; low discards all buffered data |
| pause | input | 1 | Freezes the channel while high |
| addr_lo | input | AW (4) | Low bits of the next memory byte address |
| region_left | input | RW (16) | Bytes remaining in the current memory region |
| req_valid | output | 1 | Transfer request |
| req_len | output | CW (5) | Requested byte count |
| req_ready | input | 1 | Memory side accepts the request |
| fill_valid | input | 1 | Playback byte offered |
| fill_data | input | 8 | Playback byte |
| fill_ready | output | 1 | Buffer accepts a playback byte |
| drain_valid | output | 1 | Record byte offered |
| drain_data | output | 8 | Record byte |
| drain_ready | input | 1 | Memory side takes the record byte |
| frame_tick | input | 1 | One-cycle pulse per link frame (playback) |
| tx_sample | output | LANES*8 | Sample for the outgoing slot(s) |
| tx_tag | output | 1 | Slot-valid tag for `tx_sample` |
| rx_valid | input | 1 | Sample arrived from the link (record) |
| rx_sample | input | LANES*8 | Arriving sample, low byte first |
| level | output | CW (5) | Bytes currently held |
| underrun | output | 1 | Sticky underrun flag |
| underrun_clr | input | 1 | Clears `underrun` |
| overrun | output | 1 | Sticky overrun flag |
| overrun_clr | input | 1 | Clears `overrun` |

## Verification
The two functions that can collide are a memory-side byte transfer and a link-side sample move that hit the buffer in the same cycle. In playback, that is a fill byte arriving on the same edge as a frame tick pop. In record, it is a drain byte leaving on the same edge as an arriving sample. The bench provokes each collision by driving both handshakes in one cycle at a known level. It judges the result by the level arithmetic and by the byte order of the samples and drain bytes that follow. The request-size policy is swept over all sixteen address offsets and several region lengths, and the expected lengths and request timing are computed arithmetically.

// File: rtl/abm_pkg.sv
package abm_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned BURST_BYTES = 16;

  function automatic int unsigned cap_bytes(input bit stereo);
    return stereo ? 24 : 20;
  endfunction

  function automatic int unsigned lane_bytes(input bit stereo);
    return stereo ? 4 : 2;
  endfunction
endpackage

// File: rtl/abm_byte_ring.sv
module abm_byte_ring
  import abm_pkg::*;
#(
  parameter int unsigned DEPTH = 24,
  parameter int unsigned LANES = 4,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [CW-1:0]             wr_cnt,
  input  logic [LANES*BYTE_W-1:0]   wr_data,
  input  logic [CW-1:0]             rd_cnt,
  output logic [LANES*BYTE_W-1:0]   head,
  output logic [CW-1:0]             level
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     lvl_q;

  function automatic logic [PW-1:0] wrap(input logic [PW-1:0] base, input int unsigned off);
    int unsigned s;
    s = 32'(base) + off;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_head
    assign head[l*BYTE_W +: BYTE_W] = mem[wrap(rp_q, l)];
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush) begin
      for (int l = 0; l < LANES; l++) begin
        if (l < int'(wr_cnt)) mem[wrap(wp_q, l)] <= wr_data[l*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wrap(wp_q, 32'(wr_cnt));
      rp_q  <= wrap(rp_q, 32'(rd_cnt));
      lvl_q <= lvl_q + wr_cnt - rd_cnt;
    end
  end

  assign level = lvl_q;

  AST_RING_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lvl_q) + int'(wr_cnt) - int'(rd_cnt)) <= int'(DEPTH)); // R1
  AST_RING_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= lvl_q); // R1
endmodule

// File: rtl/abm_req_sizer.sv
module abm_req_sizer
  import abm_pkg::*;
#(
  parameter bit          OUTGOING = 1'b1,
  parameter int unsigned DEPTH    = 24,
  parameter int unsigned CW       = $clog2(DEPTH + 1),
  parameter int unsigned AW       = $clog2(BURST_BYTES),
  parameter int unsigned RW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          first,
  input  logic          pend_idle,
  input  logic [CW-1:0] movable,
  input  logic [AW-1:0] addr_lo,
  input  logic [RW-1:0] region_left,
  output logic          want_valid,
  output logic [CW-1:0] want_len
);
  logic [CW-1:0] to_bnd, rgn_c, lim;
  logic          startup;

  assign to_bnd  = CW'(BURST_BYTES) - CW'(addr_lo);
  assign rgn_c   = (region_left > RW'(DEPTH)) ? CW'(DEPTH) : CW'(region_left);
  assign startup = OUTGOING && first;
  assign lim     = startup ? movable : to_bnd;
  assign want_len = (lim < rgn_c) ? lim : rgn_c;
  assign want_valid = run && pend_idle && (want_len != '0) && (movable >= want_len)
                      && (!startup || movable >= CW'(BURST_BYTES) || want_len == rgn_c);

  AST_STEADY_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (want_valid && !startup) |-> (int'(addr_lo) + int'(want_len) <= int'(BURST_BYTES))); // R3
endmodule

// File: rtl/abm_slot_port.sv
module abm_slot_port
  import abm_pkg::*;
#(
  parameter bit          OUTGOING = 1'b1,
  parameter int unsigned LANES    = 4,
  parameter int unsigned DEPTH    = 24,
  parameter int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    run,
  input  logic                    frame_tick,
  input  logic [CW-1:0]           level,
  input  logic [LANES*BYTE_W-1:0] head,
  input  logic                    rx_valid,
  input  logic [LANES*BYTE_W-1:0] rx_sample,
  output logic                    take_sample,
  output logic                    give_sample,
  output logic [LANES*BYTE_W-1:0] push_data,
  output logic [LANES*BYTE_W-1:0] tx_sample,
  output logic                    tx_tag,
  output logic                    underrun,
  input  logic                    underrun_clr,
  output logic                    overrun,
  input  logic                    overrun_clr
);
  if (OUTGOING) begin : g_tx
    logic can_pop, primed_q, hole;
    logic unused_tx;

    assign can_pop     = run && (level >= CW'(LANES));
    assign hole        = frame_tick && run && !can_pop && primed_q;
    assign take_sample = frame_tick && can_pop;
    assign give_sample = 1'b0;
    assign push_data   = '0;
    assign overrun     = 1'b0;
    assign unused_tx   = ^{rx_valid, rx_sample, overrun_clr};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tx_tag    <= 1'b0;
        tx_sample <= '0;
        primed_q  <= 1'b0;
      end else if (!enable) begin
        tx_tag   <= 1'b0;
        primed_q <= 1'b0;
      end else if (!run) begin
        tx_tag <= 1'b0;
      end else if (frame_tick) begin
        tx_tag <= can_pop;
        if (can_pop) begin
          tx_sample <= head;
          primed_q  <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)            underrun <= 1'b0;
      else if (hole)         underrun <= 1'b1;
      else if (underrun_clr) underrun <= 1'b0;
    end

    AST_TAG_LOW_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !tx_tag); // R8
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !underrun_clr) |=> underrun); // R12
    AST_TAG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && run && level < CW'(LANES)) |=> !tx_tag); // R7
  end else begin : g_rx
    logic has_room;
    logic unused_rx;

    assign has_room    = (CW'(DEPTH) - level) >= CW'(LANES);
    assign give_sample = rx_valid && run && has_room;
    assign take_sample = 1'b0;
    assign push_data   = rx_sample;
    assign tx_sample   = '0;
    assign tx_tag      = 1'b0;
    assign underrun    = 1'b0;
    assign unused_rx   = ^{frame_tick, head, underrun_clr, enable};

    always_ff @(posedge clk) begin
      if (!rst_n)                            overrun <= 1'b0;
      else if (rx_valid && run && !has_room) overrun <= 1'b1;
      else if (overrun_clr)                  overrun <= 1'b0;
    end

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !overrun_clr) |=> overrun); // R12
    AST_FULL_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && run && level == CW'(DEPTH)) |=> (level <= CW'(DEPTH))); // R11
  end
endmodule

// File: rtl/abm_stream_buf.sv
module abm_stream_buf
  import abm_pkg::*;
#(
  parameter bit          STEREO   = 1'b1,
  parameter bit          OUTGOING = 1'b1,
  parameter int unsigned LANES    = lane_bytes(STEREO),
  parameter int unsigned DEPTH    = cap_bytes(STEREO),
  parameter int unsigned RW       = 16,
  parameter int unsigned CW       = $clog2(DEPTH + 1),
  parameter int unsigned AW       = $clog2(BURST_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    pause,
  input  logic [AW-1:0]           addr_lo,
  input  logic [RW-1:0]           region_left,
  output logic                    req_valid,
  output logic [CW-1:0]           req_len,
  input  logic                    req_ready,
  input  logic                    fill_valid,
  input  logic [BYTE_W-1:0]       fill_data,
  output logic                    fill_ready,
  output logic                    drain_valid,
  output logic [BYTE_W-1:0]       drain_data,
  input  logic                    drain_ready,
  input  logic                    frame_tick,
  output logic [LANES*BYTE_W-1:0] tx_sample,
  output logic                    tx_tag,
  input  logic                    rx_valid,
  input  logic [LANES*BYTE_W-1:0] rx_sample,
  output logic [CW-1:0]           level,
  output logic                    underrun,
  input  logic                    underrun_clr,
  output logic                    overrun,
  input  logic                    overrun_clr
);
  logic                    run;
  logic [CW-1:0]           pend_q;
  logic                    first_q;
  logic [CW-1:0]           movable;
  logic                    req_fire, xfer_fire;
  logic [CW-1:0]           wr_cnt, rd_cnt;
  logic [LANES*BYTE_W-1:0] wr_data, head, push_data;
  logic                    take_sample, give_sample;

  assign run      = enable && !pause;
  assign req_fire = req_valid && req_ready;

  if (OUTGOING) begin : g_play
    logic unused_play;
    assign movable     = CW'(DEPTH) - level - pend_q;
    assign fill_ready  = run && (pend_q != '0);
    assign drain_valid = 1'b0;
    assign drain_data  = '0;
    assign xfer_fire   = fill_valid && fill_ready;
    assign wr_cnt      = xfer_fire ? CW'(1) : '0;
    assign wr_data     = {{((LANES-1)*BYTE_W){1'b0}}, fill_data};
    assign rd_cnt      = take_sample ? CW'(LANES) : '0;
    assign unused_play = ^{drain_ready, give_sample, push_data};

    AST_ROOM_FOR_OWED: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(level) + int'(pend_q)) <= int'(DEPTH)); // R1
  end else begin : g_rec
    logic unused_rec;
    assign movable     = level - pend_q;
    assign fill_ready  = 1'b0;
    assign drain_valid = run && (pend_q != '0);
    assign drain_data  = head[BYTE_W-1:0];
    assign xfer_fire   = drain_valid && drain_ready;
    assign wr_cnt      = give_sample ? CW'(LANES) : '0;
    assign wr_data     = push_data;
    assign rd_cnt      = xfer_fire ? CW'(1) : '0;
    assign unused_rec  = ^{fill_valid, fill_data, take_sample};

    AST_OWED_IS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= level); // R5
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      pend_q  <= '0;
      first_q <= 1'b1;
    end else if (req_fire) begin
      pend_q  <= req_len;
      first_q <= 1'b0;
    end else if (xfer_fire) begin
      pend_q  <= pend_q - CW'(1);
    end
  end

  abm_byte_ring #(.DEPTH(DEPTH), .LANES(LANES), .CW(CW)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (!enable),
    .wr_cnt  (wr_cnt),
    .wr_data (wr_data),
    .rd_cnt  (rd_cnt),
    .head    (head),
    .level   (level)
  );

  abm_req_sizer #(.OUTGOING(OUTGOING), .DEPTH(DEPTH), .CW(CW), .AW(AW), .RW(RW)) u_sizer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .first       (first_q),
    .pend_idle   (pend_q == '0),
    .movable     (movable),
    .addr_lo     (addr_lo),
    .region_left (region_left),
    .want_valid  (req_valid),
    .want_len    (req_len)
  );

  abm_slot_port #(.OUTGOING(OUTGOING), .LANES(LANES), .DEPTH(DEPTH), .CW(CW)) u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .run          (run),
    .frame_tick   (frame_tick),
    .level        (level),
    .head         (head),
    .rx_valid     (rx_valid),
    .rx_sample    (rx_sample),
    .take_sample  (take_sample),
    .give_sample  (give_sample),
    .push_data    (push_data),
    .tx_sample    (tx_sample),
    .tx_tag       (tx_tag),
    .underrun     (underrun),
    .underrun_clr (underrun_clr),
    .overrun      (overrun),
    .overrun_clr  (overrun_clr)
  );

  AST_DISABLE_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (level == '0)); // R9
  AST_PAUSE_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pause) |=> $stable(level)); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid); // R5
  AST_REQ_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0 && RW'(req_len) <= region_left)); // R3
endmodule

// File: tb/test_abm_stream_buf.sv
`timescale 1ns/1ps
module test_abm_stream_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // playback, stereo
  logic p_en = 0, p_ps = 0, p_rr = 0, p_fv = 0, p_dr = 0, p_tk = 0, p_rxv = 0, p_uc = 0, p_oc = 0;
  logic [3:0]  p_addr = 0;
  logic [15:0] p_rgn = 0;
  logic [7:0]  p_fd = 0;
  logic [31:0] p_rxs = 0;
  logic        p_rv, p_frdy, p_dv, p_tag, p_uf, p_of;
  logic [4:0]  p_rl, p_lvl;
  logic [7:0]  p_dd;
  logic [31:0] p_txs;

  // record, mono
  logic r_en = 0, r_ps = 0, r_rr = 0, r_fv = 0, r_dr = 0, r_tk = 0, r_rxv = 0, r_uc = 0, r_oc = 0;
  logic [3:0]  r_addr = 0;
  logic [15:0] r_rgn = 0;
  logic [7:0]  r_fd = 0;
  logic [15:0] r_rxs = 0;
  logic        r_rv, r_frdy, r_dv, r_tag, r_uf, r_of;
  logic [4:0]  r_rl, r_lvl;
  logic [7:0]  r_dd;
  logic [15:0] r_txs;

  abm_stream_buf #(.STEREO(1'b1), .OUTGOING(1'b1)) i_abm_stream_buf (
    .clk(clk), .rst_n(rst_n), .enable(p_en), .pause(p_ps), .addr_lo(p_addr),
    .region_left(p_rgn), .req_valid(p_rv), .req_len(p_rl), .req_ready(p_rr),
    .fill_valid(p_fv), .fill_data(p_fd), .fill_ready(p_frdy), .drain_valid(p_dv),
    .drain_data(p_dd), .drain_ready(p_dr), .frame_tick(p_tk), .tx_sample(p_txs),
    .tx_tag(p_tag), .rx_valid(p_rxv), .rx_sample(p_rxs), .level(p_lvl),
    .underrun(p_uf), .underrun_clr(p_uc), .overrun(p_of), .overrun_clr(p_oc));

  abm_stream_buf #(.STEREO(1'b0), .OUTGOING(1'b0)) i_abm_stream_buf_rec (
    .clk(clk), .rst_n(rst_n), .enable(r_en), .pause(r_ps), .addr_lo(r_addr),
    .region_left(r_rgn), .req_valid(r_rv), .req_len(r_rl), .req_ready(r_rr),
    .fill_valid(r_fv), .fill_data(r_fd), .fill_ready(r_frdy), .drain_valid(r_dv),
    .drain_data(r_dd), .drain_ready(r_dr), .frame_tick(r_tk), .tx_sample(r_txs),
    .tx_tag(r_tag), .rx_valid(r_rxv), .rx_sample(r_rxs), .level(r_lvl),
    .underrun(r_uf), .underrun_clr(r_uc), .overrun(r_of), .overrun_clr(r_oc));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] bv(input int base, input int i);
    return 8'((base + i) & 8'hFF);
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic run_play(input int o, input int rgn);
    int base, exp_len, w, lvl, nxt;
    base = o * 13 + rgn;
    p_en = 0; step();
    p_addr = 4'(o); p_rgn = 16'(rgn); p_en = 1; step();
    exp_len = imin(24, rgn);
    chk("R4 startup req_valid", 32'(p_rv), 1);
    chk("R4 startup req_len", 32'(p_rl), 32'(exp_len));
    p_rr = 1; step(); p_rr = 0;
    chk("R5 no request while owed", 32'(p_rv), 0);
    for (int k = 0; k < exp_len; k++) begin
      chk("R5 fill_ready while owed", 32'(p_frdy), 1);
      p_fv = 1; p_fd = bv(base, k); step();
    end
    p_fv = 0;
    chk("R5 fill_ready idle when paid", 32'(p_frdy), 0);
    chk("R1 level after fill", 32'(p_lvl), 32'(exp_len));
    w = imin(16 - o, rgn);
    lvl = exp_len; nxt = 0;
    while ((24 - lvl) < w) begin
      chk("R2 no request short of room", 32'(p_rv), 0);
      p_tk = 1; step(); p_tk = 0;
      lvl -= 4;
      chk("R6 tag on pop", 32'(p_tag), 1);
      chk("R6 sample bytes", p_txs,
          {bv(base, nxt+3), bv(base, nxt+2), bv(base, nxt+1), bv(base, nxt)});
      nxt += 4;
    end
    chk("R2 request once room", 32'(p_rv), 1);
    chk("R3 aligned length", 32'(p_rl), 32'(w));
  endtask

  task automatic run_rec(input int o, input int rgn);
    int base, w, lvl, k;
    base = o * 7 + rgn;
    r_en = 0; step();
    r_addr = 4'(o); r_rgn = 16'(rgn); r_en = 1; step();
    w = imin(16 - o, rgn);
    lvl = 0; k = 0;
    while (lvl < w) begin
      chk("R2 record no request early", 32'(r_rv), 0);
      r_rxv = 1; r_rxs = {bv(base, 2*k+1), bv(base, 2*k)}; step(); r_rxv = 0;
      lvl += 2; k++;
    end
    chk("R10 record level", 32'(r_lvl), 32'(lvl));
    chk("R2 record request", 32'(r_rv), 1);
    chk("R3 record length", 32'(r_rl), 32'(w));
    r_rr = 1; step(); r_rr = 0;
    r_dr = 1;
    for (int j = 0; j < w; j++) begin
      chk("R5 drain_valid while owed", 32'(r_dv), 1);
      chk("R10 drain order", 32'(r_dd), 32'(bv(base, j)));
      step();
    end
    r_dr = 0;
    chk("R5 drain idle when paid", 32'(r_dv), 0);
    chk("R10 level after drain", 32'(r_lvl), 32'(lvl - w));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 reset level play", 32'(p_lvl), 0);
    chk("R2 reset req play", 32'(p_rv), 0);
    chk("R6 reset tag", 32'(p_tag), 0);
    chk("R12 reset flags", {30'd0, p_uf, r_of}, 0);
    rst_n = 1; step();

    // request sizing sweep, playback
    for (int o = 0; o < 16; o++) run_play(o, 200);
    run_play(0, 3);
    run_play(5, 10);
    run_play(12, 3);
    run_play(9, 20);

    // request sizing sweep, record
    for (int o = 0; o < 16; o++) run_rec(o, 200);
    run_rec(3, 5);
    run_rec(14, 1);

    // playback: start-up, collision, pause, underrun, flags, disable
    p_en = 0; step();
    p_addr = 0; p_rgn = 200; p_en = 1; step();
    p_tk = 1; step(); p_tk = 0;
    chk("R6 no tag before data", 32'(p_tag), 0);
    chk("R7 no underrun before first sample", 32'(p_uf), 0);
    chk("R4 startup len 24", 32'(p_rl), 24);
    p_rr = 1; step(); p_rr = 0;
    for (int k = 0; k < 8; k++) begin p_fv = 1; p_fd = 8'(8'h40 + k); step(); end
    p_fv = 1; p_fd = 8'h48; p_tk = 1; step(); p_fv = 0; p_tk = 0;
    chk("R13 fill and pop same cycle", 32'(p_lvl), 5);
    chk("R6 first sample", p_txs, 32'h43424140);
    chk("R6 first tag", 32'(p_tag), 1);
    p_ps = 1; p_tk = 1; p_fv = 1; p_fd = 8'hEE; step();
    chk("R8 pause level", 32'(p_lvl), 5);
    chk("R8 pause tag", 32'(p_tag), 0);
    chk("R8 pause fill_ready", 32'(p_frdy), 0);
    chk("R8 pause no request", 32'(p_rv), 0);
    step();
    chk("R8 pause level held", 32'(p_lvl), 5);
    chk("R7 no underrun while paused", 32'(p_uf), 0);
    p_ps = 0; p_tk = 0; p_fv = 0; step();
    p_tk = 1; step(); p_tk = 0;
    chk("R8 resume sample", p_txs, 32'h47464544);
    chk("R8 resume tag", 32'(p_tag), 1);
    chk("R8 resume level", 32'(p_lvl), 1);
    p_tk = 1; step(); p_tk = 0;
    chk("R7 underrun tag", 32'(p_tag), 0);
    chk("R7 underrun flag", 32'(p_uf), 1);
    chk("R7 level kept", 32'(p_lvl), 1);
    p_uc = 1; step(); p_uc = 0;
    chk("R12 underrun cleared", 32'(p_uf), 0);
    p_uc = 1; p_tk = 1; step(); p_uc = 0; p_tk = 0;
    chk("R12 event beats clear", 32'(p_uf), 1);
    p_en = 0; step();
    chk("R9 disable empties", 32'(p_lvl), 0);
    chk("R9 disable tag", 32'(p_tag), 0);
    p_en = 1; step();
    chk("R9 startup after re-enable", 32'(p_rl), 24);
    chk("R9 request after re-enable", 32'(p_rv), 1);
    chk("R12 flag survives disable", 32'(p_uf), 1);

    // record: fill to capacity, overrun, collision, pause
    r_en = 0; step();
    r_addr = 0; r_rgn = 200; r_en = 1; step();
    for (int k = 0; k < 10; k++) begin
      r_rxv = 1; r_rxs = {8'(2*k+1), 8'(2*k)}; step();
    end
    r_rxv = 0;
    chk("R1 mono capacity", 32'(r_lvl), 20);
    chk("R11 no overrun yet", 32'(r_of), 0);
    r_rxv = 1; r_rxs = 16'hEEEE; step(); r_rxv = 0;
    chk("R11 dropped level", 32'(r_lvl), 20);
    chk("R11 overrun flag", 32'(r_of), 1);
    r_oc = 1; step(); r_oc = 0;
    chk("R12 overrun cleared", 32'(r_of), 0);
    chk("R3 record full len", 32'(r_rl), 16);
    r_rr = 1; step(); r_rr = 0;
    r_dr = 1;
    for (int j = 0; j < 2; j++) begin
      chk("R10 drain byte", 32'(r_dd), 32'(j)); step();
    end
    chk("R10 level after two", 32'(r_lvl), 18);
    chk("R13 drain byte at collision", 32'(r_dd), 2);
    r_rxv = 1; r_rxs = {8'd21, 8'd20}; step(); r_rxv = 0;
    chk("R13 push and drain same cycle", 32'(r_lvl), 19);
    for (int j = 3; j < 16; j++) begin
      chk("R10 drain byte", 32'(r_dd), 32'(j)); step();
    end
    r_dr = 0;
    chk("R5 record paid", 32'(r_dv), 0);
    chk("R10 record level rest", 32'(r_lvl), 6);
    r_ps = 1; r_rxv = 1; r_rxs = 16'h5555; step(); r_rxv = 0;
    chk("R8 record pause level", 32'(r_lvl), 6);
    chk("R8 record pause no overrun", 32'(r_of), 0);
    r_ps = 0; step();
    chk("R2 record request after resume", 32'(r_rv), 0);
    r_en = 0; step();
    chk("R9 record disable empties", 32'(r_lvl), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule